// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block collects single-bit writes from a CPU bus and assembles them into four 5-bit configuration registers. A bus write is seen when the active-low ROM select is low and the read/write line is low at a rising edge of the CPU cycle clock. There are no gated clocks: every register updates on that clock edge under an enable. Each accepted write with data bit 7 clear moves data bit 0 into a 5-bit shift register. A marker bit inside that register records how many bits have arrived, so no separate counter is kept. The fifth accepted write stores the assembled value in the register picked by the two address-select inputs on that write.

A write with data bit 7 set restarts the sequence. It also sets bits 3 and 2 of register 0, which selects the fixed-last-bank mode. Writes in back-to-back clock cycles are filtered: a write counts only if the previous cycle was a read cycle. The block drives the four register values out on one flat bus, with register k in bits [5k+4:5k].

Top module: `serial_cfg_loader`

## Requirements
- R1: After the synchronous active-high reset, register 0 reads 0x0C and registers 1 to 3 read 0. The next five accepted writes make a commit.
- R2: Each accepted write with bit 7 clear enters the value at the top and shifts the rest down. Bit 0 of the first write ends up in bit 0 of the committed value, and bit 0 of the fifth write ends up in bit 4.
- R3: On the fifth accepted write, exactly one register is loaded: the one numbered by addr_sel on that write. Register k sits at cfg_bus[5k+4:5k], and the other registers keep their values.
- R4: The addr_sel values on the first four writes of a sequence have no effect on where the commit goes.
- R5: An accepted write with bit 7 set loads no register from the shift register. It ORs register 0 with 0x0C and leaves the other registers unchanged. After it, exactly five more accepted writes are needed for a commit.
- R6: A write in the cycle right after another write cycle is ignored, whatever its address, bit 7 or bit 0. It does not shift, commit, or force mode bits.
- R7: A cycle with sel_n high, or with rd_wr high, changes no register and does not advance the sequence.
- R8: Whether the previous cycle was a write is tracked on every clock. An unselected write cycle (sel_n high, rd_wr low) therefore blocks a selected write in the next cycle.
- R9: After a commit, the next commit again needs exactly five accepted writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | ROM select, active low |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| addr_sel | input | 2 | Register number for a commit |
| data_msb | input | 1 | Data bit 7 (sequence restart) |
| data_lsb | input | 1 | Data bit 0 (serial bit) |
| cfg_bus | output | 20 | Four 5-bit registers, register k at [5k+4:5k] |

## Verification
The bench targets several wrong-design failures:
- A design that counts the restart write as the first bit commits one write early. The bench checks that four writes after a restart change nothing.
- A design that filters back-to-back writes only when they are selected accepts a write that follows an unselected write cycle.
- A design that filters on address is caught by a back-to-back pair that follows a commit. The second write of that pair has bit 7 set and a different address, and the bench checks that register 0 and the alignment of the following sequence are untouched.
- A design that latches the target address early is caught by sequences whose first four writes use scattered addresses.

A behavioural model runs alongside the design on every clock, including a long random mix of cycles.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int CFG_W     = 5;
  localparam int CFG_COUNT = 4;
  localparam logic [CFG_W-1:0] CFG_MODE_FORCE = 5'b01100;
endpackage

// File: rtl/cfg_write_filter.sv
module cfg_write_filter (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic rd_wr,
  output logic accept
);
  logic last_was_read;

  always_ff @(posedge clk) begin
    if (rst) last_was_read <= 1'b1;
    else     last_was_read <= rd_wr;
  end

  assign accept = !sel_n && !rd_wr && last_was_read;
endmodule

// File: rtl/cfg_marker_shift.sv
module cfg_marker_shift #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             restart,
  input  logic             bit_in,
  output logic             commit,
  output logic [WIDTH-1:0] commit_val
);
  localparam logic [WIDTH-1:0] EMPTY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] shifted;

  assign shifted    = {bit_in, shreg[WIDTH-1:1]};
  assign commit     = accept && !restart && shreg[0];
  assign commit_val = shifted;

  always_ff @(posedge clk) begin
    if (rst)                       shreg <= EMPTY;
    else if (accept && restart)    shreg <= EMPTY;
    else if (commit)               shreg <= EMPTY;
    else if (accept)               shreg <= shifted;
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int WIDTH = 5,
  parameter int COUNT = 4,
  parameter logic [WIDTH-1:0] MODE_FORCE = 5'b01100,
  localparam int SEL_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   commit,
  input  logic [SEL_W-1:0]       commit_sel,
  input  logic [WIDTH-1:0]       commit_val,
  input  logic                   force_mode,
  output logic [COUNT*WIDTH-1:0] cfg_bus
);
  for (genvar g = 0; g < COUNT; g++) begin : g_reg
    logic [WIDTH-1:0] value;
    always_ff @(posedge clk) begin
      if (rst)
        value <= (g == 0) ? MODE_FORCE : '0;
      else if (commit && commit_sel == SEL_W'(g))
        value <= commit_val;
      else if (force_mode && g == 0)
        value <= value | MODE_FORCE;
    end
    assign cfg_bus[g*WIDTH +: WIDTH] = value;
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int REG_W    = serial_cfg_pkg::CFG_W,
  parameter int NUM_REGS = serial_cfg_pkg::CFG_COUNT,
  parameter logic [REG_W-1:0] MODE_FORCE = serial_cfg_pkg::CFG_MODE_FORCE,
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel_n,
  input  logic                      rd_wr,
  input  logic [SEL_W-1:0]          addr_sel,
  input  logic                      data_msb,
  input  logic                      data_lsb,
  output logic [NUM_REGS*REG_W-1:0] cfg_bus
);
  logic             accept;
  logic             commit;
  logic [REG_W-1:0] commit_val;

  cfg_write_filter u_filter (
    .clk    (clk),
    .rst    (rst),
    .sel_n  (sel_n),
    .rd_wr  (rd_wr),
    .accept (accept)
  );

  cfg_marker_shift #(.WIDTH(REG_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .restart    (data_msb),
    .bit_in     (data_lsb),
    .commit     (commit),
    .commit_val (commit_val)
  );

  cfg_reg_bank #(.WIDTH(REG_W), .COUNT(NUM_REGS), .MODE_FORCE(MODE_FORCE)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .commit_sel (addr_sel),
    .commit_val (commit_val),
    .force_mode (accept && data_msb),
    .cfg_bus    (cfg_bus)
  );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
  parameter int REG_W    = 5,
  parameter int NUM_REGS = 4,
  parameter logic [REG_W-1:0] MODE_FORCE = 5'b01100,
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      sel_n,
  input logic                      rd_wr,
  input logic [SEL_W-1:0]          addr_sel,
  input logic                      data_msb,
  input logic                      data_lsb,
  input logic [NUM_REGS*REG_W-1:0] cfg_bus
);
  localparam logic [NUM_REGS*REG_W-1:0] RESET_BUS = {{((NUM_REGS-1)*REG_W){1'b0}}, MODE_FORCE};

  logic                      past_rst;
  logic                      past_rw;
  logic [NUM_REGS*REG_W-1:0] past_bus;
  logic [NUM_REGS-1:0]       changed;

  always_ff @(posedge clk) begin
    past_rst <= rst;
    past_rw  <= rd_wr;
    past_bus <= cfg_bus;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
    assign changed[g] = cfg_bus[g*REG_W +: REG_W] != past_bus[g*REG_W +: REG_W];
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    past_rst |-> cfg_bus == RESET_BUS); // R1

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !past_rst |-> $onehot0(changed)); // R3

  AST_MODE_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !rd_wr && past_rw && data_msb) |=> cfg_bus[3:2] == 2'b11); // R5

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !rd_wr && !past_rw && !past_rst) |=> $stable(cfg_bus)); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sel_n || rd_wr) |=> $stable(cfg_bus)); // R7
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
  .REG_W(REG_W), .NUM_REGS(NUM_REGS), .MODE_FORCE(MODE_FORCE)
) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .rd_wr(rd_wr), .addr_sel(addr_sel),
  .data_msb(data_msb), .data_lsb(data_lsb), .cfg_bus(cfg_bus)
);

// File: tb/tb_serial_cfg_loader.sv
`timescale 1ns/1ps
module tb_serial_cfg_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b1;
  logic        rd_wr = 1'b1;
  logic [1:0]  addr_sel = '0;
  logic        data_msb = 1'b0;
  logic        data_lsb = 1'b0;
  logic [19:0] cfg_bus;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int m_cfg [4];
  int m_shift;
  int m_count;
  bit m_prev_rd;

  always #4 clk = ~clk;

  serial_cfg_loader dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .rd_wr(rd_wr), .addr_sel(addr_sel),
    .data_msb(data_msb), .data_lsb(data_lsb), .cfg_bus(cfg_bus)
  );

  function automatic int get_reg(int k);
    return int'(cfg_bus[k*5 +: 5]);
  endfunction

  task automatic check_val(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    for (int k = 0; k < 4; k++)
      check_val(cur_req, $sformatf("model cfg%0d", k), get_reg(k), m_cfg[k]);
  endtask

  task automatic model_reset();
    m_cfg[0] = 'h0C; m_cfg[1] = 0; m_cfg[2] = 0; m_cfg[3] = 0;
    m_shift = 0; m_count = 0; m_prev_rd = 1'b1;
  endtask

  task automatic cycle(bit s, bit rw, int a, bit d7, bit d0);
    bit acc;
    sel_n = s; rd_wr = rw; addr_sel = 2'(a); data_msb = d7; data_lsb = d0;
    @(posedge clk);
    acc = !s && !rw && m_prev_rd;
    m_prev_rd = rw;
    if (acc) begin
      if (d7) begin
        m_cfg[0] = m_cfg[0] | 'h0C;
        m_count = 0; m_shift = 0;
      end else begin
        m_shift = m_shift | (int'(d0) << m_count);
        m_count++;
        if (m_count == 5) begin
          m_cfg[a] = m_shift;
          m_count = 0; m_shift = 0;
        end
      end
    end
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(int a, bit d7, bit d0);
    cycle(1'b0, 1'b0, a, d7, d0);
    cycle(1'b1, 1'b1, 0, 1'b0, 1'b0);
  endtask

  task automatic load(int a, int val);
    for (int i = 0; i < 5; i++) wr(a, 1'b0, val[i]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sel_n = 1'b1; rd_wr = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    cur_req = "R1";
    check_val("R1", "cfg0 after reset", get_reg(0), 'h0C);
    check_val("R1", "cfg1 after reset", get_reg(1), 0);
    check_val("R1", "cfg3 after reset", get_reg(3), 0);
    for (int i = 0; i < 4; i++) wr(2, 1'b0, 1'b1);
    check_val("R1", "no commit after four writes", get_reg(2), 0);
    wr(2, 1'b0, 1'b1);
    check_val("R1", "fifth write commits", get_reg(2), 'h1F);

    cur_req = "R2";
    load(1, 'h15);
    check_val("R2", "bit order cfg1", get_reg(1), 'h15);
    load(3, 'h0A);
    check_val("R2", "bit order cfg3", get_reg(3), 'h0A);
    cur_req = "R3";
    load(0, 'h03);
    check_val("R3", "cfg0 loaded", get_reg(0), 'h03);
    check_val("R3", "cfg1 untouched", get_reg(1), 'h15);

    cur_req = "R4";
    wr(3, 1'b0, 1'b0); wr(0, 1'b0, 1'b1); wr(1, 1'b0, 1'b1); wr(3, 1'b0, 1'b0);
    wr(2, 1'b0, 1'b0);
    check_val("R4", "target from fifth write", get_reg(2), 'h06);
    check_val("R4", "cfg3 untouched", get_reg(3), 'h0A);

    cur_req = "R5";
    wr(1, 1'b0, 1'b1); wr(1, 1'b0, 1'b1);
    wr(2, 1'b1, 1'b0);
    check_val("R5", "mode bits forced", get_reg(0), 'h0F);
    check_val("R5", "cfg2 not loaded", get_reg(2), 'h06);
    for (int i = 0; i < 4; i++) wr(1, 1'b0, 1'b1);
    check_val("R5", "restart write not counted", get_reg(1), 'h15);
    wr(1, 1'b0, 1'b0);
    check_val("R5", "commit after five more", get_reg(1), 'h0F);

    cur_req = "R6";
    load(0, 'h00);
    wr(3, 1'b0, 1'b1); wr(3, 1'b0, 1'b0); wr(3, 1'b0, 1'b1); wr(3, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 3, 1'b0, 1'b1);
    cycle(1'b0, 1'b0, 0, 1'b1, 1'b0);
    cycle(1'b1, 1'b1, 0, 1'b0, 1'b0);
    check_val("R6", "first of pair commits", get_reg(3), 'h15);
    check_val("R6", "second of pair ignored", get_reg(0), 'h00);
    load(3, 'h11);
    check_val("R6", "alignment after filtered write", get_reg(3), 'h11);

    cur_req = "R8";
    cycle(1'b1, 1'b0, 0, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 0, 1'b1, 1'b0);
    cycle(1'b1, 1'b1, 0, 1'b0, 1'b0);
    check_val("R8", "write after unselected write blocked", get_reg(0), 'h00);
    load(2, 'h09);
    check_val("R8", "alignment kept", get_reg(2), 'h09);

    cur_req = "R7";
    cycle(1'b0, 1'b1, 0, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 0, 1'b1, 1'b1);
    check_val("R7", "reads change nothing", get_reg(0), 'h00);
    load(1, 'h12);
    check_val("R7", "sequence not advanced", get_reg(1), 'h12);

    cur_req = "R9";
    load(2, 'h1F);
    for (int i = 0; i < 4; i++) wr(2, 1'b0, (i == 0));
    check_val("R9", "no early second commit", get_reg(2), 'h1F);
    wr(2, 1'b0, 1'b0);
    check_val("R9", "second commit", get_reg(2), 'h01);

    cur_req = "R3";
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 15));
      cycle(r[0] & r[1], r[2], int'($urandom_range(0, 3)), (r == 15), bit'($urandom_range(0, 1)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule